// File: doc/BRIEF.md
# Presettable Synchronous Modulo-16 Counter

This block is a synchronous binary up-counter, four bits wide by default, meant as one stage of a programmable divider or of a longer counter. Every change of its state happens on the rising clock edge. On each edge it performs one of four actions, chosen by a fixed priority. A low clear input zeroes the count. Otherwise a low load input copies a parallel data word into the count. Otherwise the count steps up by one when both enables are high. Otherwise the count holds.

There are two count enables. One of them also gates the terminal-count output, so stages can be chained in lookahead form. In that form, each later stage takes its trickle enable from the previous stage's terminal count, and every later stage takes its parallel enable from the first stage's terminal count. The terminal-count output is combinational: it is formed from the registered count and the live trickle enable. It is meant only as an enable for other stages. The count is undefined until the first clear or load.

Top module: `presettable_ctr`

## Requirements
- R1: With clear_n and load_n high and both en_par and en_trk high, each rising edge adds one to count modulo 2^WIDTH, so 15 (1111) is followed by 0 (0000).
- R2: count changes only at a rising clock edge; changing any input between edges leaves count unchanged.
- R3: The action at an edge follows the priority clear, then load, then count, then hold, for every combination of the four control inputs.
- R4: clear_n low at an edge makes count 0, whatever load_n, en_par and en_trk are.
- R5: clear_n high and load_n low at an edge make count equal to load_val, whatever en_par and en_trk are.
- R6: With clear_n and load_n high, count holds its value if en_par or en_trk is low.
- R7: term_cnt is high exactly when en_trk is high and count is all ones (15); it does not depend on en_par, load_n or clear_n.
- R8: term_cnt follows en_trk at once, with no clock edge needed.
- R9: Two stages in lookahead form count as one 8-bit counter, the upper stage moving only when the lower stage's term_cnt is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| clear_n | input | 1 | Synchronous clear, active low, highest priority |
| load_n | input | 1 | Synchronous parallel load, active low |
| en_par | input | 1 | Count enable that does not reach term_cnt |
| en_trk | input | 1 | Count enable that also gates term_cnt |
| load_val | input | WIDTH | Parallel data word for a load |
| count | output | WIDTH | Registered count |
| term_cnt | output | 1 | High when en_trk is high and count is all ones |

## Verification
Clear, load and count can all be requested at the same edge, and so can count and the wrap from 15 to 0. The bench preloads 9 and then 15, and next applies all sixteen settings of the four control inputs with a different load word. It compares each result against a priority model written from the requirements. The case with the count at 15 shows that clear or load wins over the wrap. The same pass checks that term_cnt responds only to en_trk and the count.

// File: rtl/ctr_pkg.sv
package ctr_pkg;

   // Action taken at the next rising edge, in priority order.
   typedef enum logic [1:0] {
      CM_CLEAR = 2'd0,
      CM_LOAD  = 2'd1,
      CM_COUNT = 2'd2,
      CM_HOLD  = 2'd3
   } ctr_mode_e;

   // Carry-chain implementation choices for the incrementer.
   localparam int unsigned CARRY_ADDER = 0;
   localparam int unsigned CARRY_CHAIN = 1;

endpackage

// File: rtl/ctr_mode_sel.sv
module ctr_mode_sel
   import ctr_pkg::*;
(
   input  logic      clear_n,
   input  logic      load_n,
   input  logic      en_par,
   input  logic      en_trk,
   output ctr_mode_e mode
);

   // Fixed priority: clear beats load, load beats count, count beats hold.
   always_comb begin
      if (!clear_n)
         mode = CM_CLEAR;
      else if (!load_n)
         mode = CM_LOAD;
      else if (en_par && en_trk)
         mode = CM_COUNT;
      else
         mode = CM_HOLD;
   end

endmodule

// File: rtl/ctr_next.sv
module ctr_next
   import ctr_pkg::*;
#(
   parameter int unsigned WIDTH       = 4,
   parameter int unsigned CARRY_STYLE = CARRY_CHAIN
) (
   input  ctr_mode_e        mode,
   input  logic [WIDTH-1:0] cur,
   input  logic [WIDTH-1:0] load_val,
   output logic [WIDTH-1:0] nxt
);

   logic [WIDTH-1:0] inc;

   generate
      if (CARRY_STYLE == CARRY_ADDER) begin : g_adder
         assign inc = cur + WIDTH'(1);
      end else begin : g_chain
         // ones_below[i] is high when every bit under position i is set.
         logic [WIDTH:0] ones_below;
         assign ones_below[0] = 1'b1;
         for (genvar i = 0; i < WIDTH; i++) begin : g_bit
            assign ones_below[i+1] = ones_below[i] & cur[i];
            assign inc[i]          = cur[i] ^ ones_below[i];
         end
      end
   endgenerate

   always_comb begin
      unique case (mode)
         CM_CLEAR: nxt = '0;
         CM_LOAD:  nxt = load_val;
         CM_COUNT: nxt = inc;
         default:  nxt = cur;
      endcase
   end

endmodule

// File: rtl/ctr_term.sv
module ctr_term #(
   parameter int unsigned WIDTH = 4
) (
   input  logic [WIDTH-1:0] cur,
   input  logic             en_trk,
   output logic             term
);

   // Full-count detect, gated only by the trickle enable.
   assign term = en_trk & (&cur);

endmodule

// File: rtl/presettable_ctr.sv
module presettable_ctr
   import ctr_pkg::*;
#(
   parameter int unsigned WIDTH       = 4,
   parameter int unsigned CARRY_STYLE = CARRY_CHAIN
) (
   input  logic             clk,
   input  logic             clear_n,
   input  logic             load_n,
   input  logic             en_par,
   input  logic             en_trk,
   input  logic [WIDTH-1:0] load_val,
   output logic [WIDTH-1:0] count,
   output logic             term_cnt
);

   generate
      if (WIDTH < 1) begin : g_bad_width
         $error("presettable_ctr: WIDTH must be at least 1");
      end
      if (CARRY_STYLE > CARRY_CHAIN) begin : g_bad_style
         $error("presettable_ctr: unknown CARRY_STYLE");
      end
   endgenerate

   ctr_mode_e        mode;
   logic [WIDTH-1:0] cnt_q;
   logic [WIDTH-1:0] cnt_d;

   ctr_mode_sel u_mode (
      .clear_n (clear_n),
      .load_n  (load_n),
      .en_par  (en_par),
      .en_trk  (en_trk),
      .mode    (mode)
   );

   ctr_next #(
      .WIDTH       (WIDTH),
      .CARRY_STYLE (CARRY_STYLE)
   ) u_next (
      .mode     (mode),
      .cur      (cnt_q),
      .load_val (load_val),
      .nxt      (cnt_d)
   );

   // No asynchronous path: the state register sees only the clock.
   always_ff @(posedge clk) begin
      cnt_q <= cnt_d;
   end

   ctr_term #(
      .WIDTH (WIDTH)
   ) u_term (
      .cur    (cnt_q),
      .en_trk (en_trk),
      .term   (term_cnt)
   );

   assign count = cnt_q;

endmodule

// File: rtl/presettable_ctr_chk.sv
module presettable_ctr_chk #(
   parameter int unsigned WIDTH = 4
) (
   input logic             clk,
   input logic             clear_n,
   input logic             load_n,
   input logic             en_par,
   input logic             en_trk,
   input logic [WIDTH-1:0] load_val,
   input logic [WIDTH-1:0] count,
   input logic             term_cnt
);

   // The count is only defined after the first clear or load edge.
   logic seen = 1'b0;
   always_ff @(posedge clk) begin
      if (!clear_n || !load_n)
         seen <= 1'b1;
   end

   a_r4_clear_zero: assert property (@(posedge clk) disable iff (!seen)
      !clear_n |=> count == '0);

   a_r5_load_word: assert property (@(posedge clk) disable iff (!seen)
      (clear_n && !load_n) |=> count == $past(load_val));

   a_r1_step_up: assert property (@(posedge clk) disable iff (!seen)
      (clear_n && load_n && en_par && en_trk) |=> count == WIDTH'($past(count) + 1'b1));

   a_r6_hold: assert property (@(posedge clk) disable iff (!seen)
      (clear_n && load_n && !(en_par && en_trk)) |=> $stable(count));

   a_r7_term_high: assert property (@(posedge clk) disable iff (!seen)
      term_cnt |-> (en_trk && count == {WIDTH{1'b1}}));

   a_r7_term_low: assert property (@(posedge clk) disable iff (!seen)
      (en_trk && count == {WIDTH{1'b1}}) |-> term_cnt);

endmodule

bind presettable_ctr presettable_ctr_chk #(.WIDTH(WIDTH)) u_chk (
   .clk      (clk),
   .clear_n  (clear_n),
   .load_n   (load_n),
   .en_par   (en_par),
   .en_trk   (en_trk),
   .load_val (load_val),
   .count    (count),
   .term_cnt (term_cnt)
);

// File: tb/sim_presettable_ctr.sv
`timescale 1ns/1ps
module sim_presettable_ctr;

   logic       clk = 1'b0;
   logic       clear_n = 1'b1, load_n = 1'b1, en_par = 1'b0, en_trk = 1'b0;
   logic [3:0] load_val = 4'd0;
   logic [3:0] count;
   logic       term_cnt;

   // Two-stage lookahead cascade.
   logic       c_clear_n = 1'b1, c_run = 1'b0;
   logic [3:0] lo_q, hi_q;
   logic       lo_tc, hi_tc;

   int n_chk = 0;
   int n_fail = 0;

   always #2.5 clk = ~clk;

   presettable_ctr u0 (
      .clk(clk), .clear_n(clear_n), .load_n(load_n), .en_par(en_par),
      .en_trk(en_trk), .load_val(load_val), .count(count), .term_cnt(term_cnt)
   );

   presettable_ctr u_lo (
      .clk(clk), .clear_n(c_clear_n), .load_n(1'b1), .en_par(c_run),
      .en_trk(c_run), .load_val(4'd0), .count(lo_q), .term_cnt(lo_tc)
   );

   presettable_ctr u_hi (
      .clk(clk), .clear_n(c_clear_n), .load_n(1'b1), .en_par(lo_tc),
      .en_trk(lo_tc), .load_val(4'd0), .count(hi_q), .term_cnt(hi_tc)
   );

   task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // Wait for the next rising edge, then move 1 ns away from it.
   task automatic step();
      @(posedge clk);
      #1;
   endtask

   function automatic logic [3:0] model(input logic c, input logic l,
                                        input logic p, input logic t,
                                        input logic [3:0] d, input logic [3:0] q);
      if (!c)         return 4'd0;
      else if (!l)    return d;
      else if (p && t) return q + 4'd1;
      else            return q;
   endfunction

   task automatic t_clear();
      clear_n = 1'b0; load_n = 1'b0; en_par = 1'b1; en_trk = 1'b1; load_val = 4'd7;
      step();
      chk("R4 clear overrides all", {4'd0, count}, 8'd0);
      chk("R7 no tc at zero", {7'd0, term_cnt}, 8'd0);
      clear_n = 1'b1; load_n = 1'b1;
   endtask

   task automatic t_modes();
      logic [3:0] starts [2] = '{4'd9, 4'd15};
      foreach (starts[s]) begin
         for (int m = 0; m < 16; m++) begin
            clear_n = 1'b1; load_n = 1'b0; load_val = starts[s]; en_par = 1'b0; en_trk = 1'b0;
            step();
            chk("R5 preload", {4'd0, count}, {4'd0, starts[s]});
            clear_n = m[3]; load_n = m[2]; en_par = m[1]; en_trk = m[0]; load_val = 4'd5;
            step();
            chk("R3 priority model", {4'd0, count},
                {4'd0, model(m[3], m[2], m[1], m[0], 4'd5, starts[s])});
            chk("R7 tc from en_trk and count", {7'd0, term_cnt},
                {7'd0, (m[0] && count == 4'd15)});
         end
      end
      clear_n = 1'b1; load_n = 1'b1; en_par = 1'b0; en_trk = 1'b0;
   endtask

   task automatic t_wrap();
      load_n = 1'b0; load_val = 4'd13;
      step();
      load_n = 1'b1; en_par = 1'b1; en_trk = 1'b1;
      step(); chk("R1 step to 14", {4'd0, count}, 8'd14);
      step(); chk("R1 step to 15", {4'd0, count}, 8'd15);
      chk("R7 tc at 15", {7'd0, term_cnt}, 8'd1);
      en_par = 1'b0; #0.5;
      chk("R7 tc ignores en_par", {7'd0, term_cnt}, 8'd1);
      load_n = 1'b0; clear_n = 1'b0; #0.5;
      chk("R7 tc ignores load_n and clear_n", {7'd0, term_cnt}, 8'd1);
      en_trk = 1'b0; #0.5;
      chk("R8 tc drops with en_trk, no edge", {7'd0, term_cnt}, 8'd0);
      en_trk = 1'b1; #0.5;
      chk("R8 tc rises with en_trk, no edge", {7'd0, term_cnt}, 8'd1);
      en_par = 1'b0;
      step();
      chk("R4 clear at 15", {4'd0, count}, 8'd0);
      clear_n = 1'b1; load_n = 1'b0; load_val = 4'd15;
      step();
      load_n = 1'b1; en_par = 1'b0;
      step(); chk("R6 hold with en_par low", {4'd0, count}, 8'd15);
      en_par = 1'b1; en_trk = 1'b0;
      step(); chk("R6 hold with en_trk low", {4'd0, count}, 8'd15);
      en_trk = 1'b1;
      step(); chk("R1 wrap 15 to 0", {4'd0, count}, 8'd0);
      en_par = 1'b0; en_trk = 1'b0;
   endtask

   task automatic t_edge_only();
      load_n = 1'b0; load_val = 4'd3;
      step();
      load_n = 1'b1;
      // Mid-cycle activity on every control input.
      clear_n = 1'b0; #0.5; clear_n = 1'b1;
      load_n = 1'b0; load_val = 4'd10; #0.5; load_n = 1'b1;
      en_par = 1'b1; en_trk = 1'b1; #0.5; en_par = 1'b0; en_trk = 1'b0;
      chk("R2 no change between edges", {4'd0, count}, 8'd3);
      step();
      chk("R2 hold at edge", {4'd0, count}, 8'd3);
   endtask

   task automatic t_cascade();
      c_clear_n = 1'b0;
      step();
      chk("R9 cascade cleared", {hi_q, lo_q}, 8'd0);
      c_clear_n = 1'b1; c_run = 1'b1;
      for (int i = 1; i <= 300; i++) begin
         step();
         chk("R9 8-bit cascade count", {hi_q, lo_q}, 8'(i));
      end
      c_run = 1'b0;
      step();
      chk("R9 cascade holds", {hi_q, lo_q}, 8'(300));
   endtask

   initial begin
      #(200000 * 5);
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      @(negedge clk);
      t_clear();
      t_modes();
      t_wrap();
      t_edge_only();
      t_cascade();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule